// File: doc/BRIEF.md
# Hybrid Network Message Injection Controller

This block sits between a processor core and its local router on the electrical control plane of a mesh that pairs electrical packet links with an optical circuit plane. The core presents one message request at a time, made of a destination tile and a length in flits. The block compares the length with a programmable threshold. Messages at or below the threshold pass straight through to the electrical packet network. Longer messages join a small queue of pending optical circuit requests.

For the request at the head of that queue, the block sends a one-cycle setup message into the control network. It then waits for the router to answer with a grant or a failure. A failure, or a response that does not arrive within a programmable number of cycles, counts as a failed attempt. After a timeout the block first sends a teardown to release whatever part of the path was reserved. Every failed attempt is followed by a backoff wait. The wait starts short and doubles on each consecutive failure, up to a cap. When a grant arrives, the block tells the optical side that bulk transfer may begin. When the optical side reports the final beat, the block sends a teardown, retires the request and moves to the next one. A source never holds more than one circuit at a time.

Top module: `hnet_inject_ctrl`

## Requirements
- R1: A request with `req_len <= cfg_threshold` appears at once on `pkt_valid`, `pkt_dest` and `pkt_len`, and `req_ready` follows `pkt_ready` for it.
- R2: A request with `req_len > cfg_threshold` never raises `pkt_valid`. It is accepted into the circuit queue whenever the queue has room.
- R3: The circuit queue holds 8 requests, counting the one in progress. With 8 pending, `req_ready` is low for a long request and still follows `pkt_ready` for a short one.
- R4: A circuit attempt raises `ctl_valid` with `ctl_kind` = 0 (setup) and `ctl_dest` equal to the head destination. These values hold steady until `ctl_ready` is seen.
- R5: A response with `resp_grant` = 1, received while waiting, raises `xfer_go` on the next cycle, with `xfer_dest` and `xfer_len` taken from the request.
- R6: A response with `resp_grant` = 0 puts the block in backoff. The setup is sent again after exactly D cycles, where D is 4 for the first consecutive failure and doubles on each further one, capped at 256.
- R7: A grant resets the backoff delay, so the next failure waits 4 cycles again.
- R8: If no response arrives within `cfg_timeout` cycles after the setup is accepted, the block sends `ctl_kind` = 1 (teardown) for that destination. This counts as a failure and is followed by the doubled backoff.
- R9: The cycle after `xfer_done` is seen during a transfer, a teardown for the same destination is presented. No setup is sent while `xfer_go` is high. Queued requests are served in arrival order.
- R10: After reset, `ctl_valid`, `xfer_go` and `pkt_valid` are low (the last while `req_valid` is low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_threshold | input | LEN_W | Largest length, in flits, sent on the packet network |
| cfg_timeout | input | TO_W | Cycles to wait for a setup response (at least 1) |
| req_valid | input | 1 | Core presents a message request |
| req_ready | output | 1 | Request taken this cycle |
| req_dest | input | DEST_W | Destination tile of the request |
| req_len | input | LEN_W | Message length in flits |
| pkt_valid | output | 1 | Short message offered to the packet network |
| pkt_ready | input | 1 | Packet network takes the message |
| pkt_dest | output | DEST_W | Destination of the short message |
| pkt_len | output | LEN_W | Length of the short message |
| ctl_valid | output | 1 | Control message offered to the router |
| ctl_ready | input | 1 | Router takes the control message |
| ctl_kind | output | 1 | 0 = path setup, 1 = path teardown |
| ctl_dest | output | DEST_W | Destination the path leads to |
| resp_valid | input | 1 | Router returns a setup outcome |
| resp_grant | input | 1 | 1 = path granted, 0 = blocked |
| xfer_go | output | 1 | Circuit held; optical transfer may proceed |
| xfer_dest | output | DEST_W | Destination of the circuit transfer |
| xfer_len | output | LEN_W | Length of the circuit transfer |
| xfer_done | input | 1 | Final data beat of the transfer has gone |

## Verification
The bench uses the default widths: 6-bit destinations, 12-bit lengths and a queue depth of 8. It sets `cfg_timeout` to 20, so a timeout occurs within a short run. Eight failures in a row on one request take the backoff delay from 4 up to the 256-cycle cap and keep it there. A random threshold per trial, together with directed lengths at the threshold and one above it, covers both sides of the steering decision. Holding `ctl_ready` low fills the queue to its depth, which exposes the stall and the arrival order.

// File: rtl/hnet_pkg.sv
package hnet_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_ABORT,
    ST_BACKOFF,
    ST_XFER,
    ST_TEARDOWN
  } circ_state_e;

  localparam logic CTL_SETUP    = 1'b0;
  localparam logic CTL_TEARDOWN = 1'b1;

endpackage

// File: rtl/hnet_setup_fifo.sv
module hnet_setup_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = push ? ptr_inc(wptr_q) : wptr_q;
    rptr_d = pop  ? ptr_inc(rptr_q) : rptr_q;
    cnt_d  = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (!push && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wptr_q] <= push_data;
  end

  assign head  = mem_q[rptr_q];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R9

endmodule

// File: rtl/hnet_backoff.sv
module hnet_backoff #(
  parameter int INIT = 4,
  parameter int MAX  = 256,
  parameter int W    = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fail,
  input  logic         success,
  input  logic         run,
  output logic         expire,
  output logic [W-1:0] delay
);

  localparam logic [W-1:0] INIT_V = W'(INIT);
  localparam logic [W-1:0] MAX_V  = W'(MAX);
  localparam logic [W-1:0] HALF_V = W'(MAX / 2);

  logic [W-1:0] dly_q, dly_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    dly_d = dly_q;
    if (success)   dly_d = INIT_V;
    else if (fail) dly_d = (dly_q >= HALF_V) ? MAX_V : (dly_q << 1);
  end

  assign cnt_en = fail || (run && !expire);

  always_comb begin
    cnt_d = cnt_q;
    if (fail)                cnt_d = dly_q;
    else if (run && !expire) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= INIT_V;
      cnt_q <= INIT_V;
    end else begin
      dly_q <= dly_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign expire = (cnt_q == W'(1));
  assign delay  = dly_q;

  AST_BO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q >= INIT_V) && (dly_q <= MAX_V)); // R6

  AST_BO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    success |=> (delay == INIT_V)); // R7

endmodule

// File: rtl/hnet_circuit_fsm.sv
module hnet_circuit_fsm
  import hnet_pkg::*;
#(
  parameter int DEST_W = 6,
  parameter int LEN_W  = 12,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [DEST_W-1:0] head_dest,
  input  logic [LEN_W-1:0]  head_len,
  input  logic [TO_W-1:0]   cfg_timeout,
  output logic              ctl_valid,
  input  logic              ctl_ready,
  output logic              ctl_kind,
  output logic [DEST_W-1:0] ctl_dest,
  input  logic              resp_valid,
  input  logic              resp_grant,
  output logic              xfer_go,
  output logic [DEST_W-1:0] xfer_dest,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done,
  output logic              q_pop,
  output logic              bo_fail,
  output logic              bo_success,
  output logic              bo_run,
  input  logic              bo_expire
);

  circ_state_e     state_q, state_d;
  logic [TO_W-1:0] timer_q, timer_d;
  logic            timer_en;

  always_comb begin
    state_d    = state_q;
    timer_d    = timer_q;
    q_pop      = 1'b0;
    bo_fail    = 1'b0;
    bo_success = 1'b0;
    case (state_q)
      ST_IDLE: if (!q_empty) state_d = ST_SETUP;
      ST_SETUP: begin
        if (ctl_ready) begin
          state_d = ST_WAIT;
          timer_d = '0;
        end
      end
      ST_WAIT: begin
        if (resp_valid) begin
          if (resp_grant) begin
            state_d    = ST_XFER;
            bo_success = 1'b1;
          end else begin
            state_d = ST_BACKOFF;
            bo_fail = 1'b1;
          end
        end else if (timer_q == cfg_timeout - 1'b1) begin
          state_d = ST_ABORT;
        end else begin
          timer_d = timer_q + 1'b1;
        end
      end
      ST_ABORT: begin
        if (ctl_ready) begin
          state_d = ST_BACKOFF;
          bo_fail = 1'b1;
        end
      end
      ST_BACKOFF: if (bo_expire) state_d = ST_SETUP;
      ST_XFER:    if (xfer_done) state_d = ST_TEARDOWN;
      ST_TEARDOWN: begin
        if (ctl_ready) begin
          state_d = ST_IDLE;
          q_pop   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign timer_en = (state_q == ST_SETUP) || (state_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
    end else begin
      state_q <= state_d;
      if (timer_en) timer_q <= timer_d;
    end
  end

  assign ctl_valid = (state_q == ST_SETUP) || (state_q == ST_ABORT) ||
                     (state_q == ST_TEARDOWN);
  assign ctl_kind  = (state_q == ST_SETUP) ? CTL_SETUP : CTL_TEARDOWN;
  assign ctl_dest  = head_dest;
  assign xfer_go   = (state_q == ST_XFER);
  assign xfer_dest = head_dest;
  assign xfer_len  = head_len;
  assign bo_run    = (state_q == ST_BACKOFF);

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_kind) && $stable(ctl_dest))); // R4

  AST_GRANT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_go) |-> $past(resp_valid && resp_grant)); // R5

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && (cfg_timeout != '0)) |-> (timer_q < cfg_timeout)); // R8

  AST_TD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && xfer_done) |=> (ctl_valid && (ctl_kind == CTL_TEARDOWN))); // R9

  AST_ONE_CIRCUIT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> !ctl_valid); // R9

endmodule

// File: rtl/hnet_inject_ctrl.sv
module hnet_inject_ctrl #(
  parameter int DEST_W  = 6,
  parameter int LEN_W   = 12,
  parameter int TO_W    = 16,
  parameter int QDEPTH  = 8,
  parameter int BO_INIT = 4,
  parameter int BO_MAX  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_threshold,
  input  logic [TO_W-1:0]   cfg_timeout,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DEST_W-1:0] req_dest,
  input  logic [LEN_W-1:0]  req_len,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [DEST_W-1:0] pkt_dest,
  output logic [LEN_W-1:0]  pkt_len,
  output logic              ctl_valid,
  input  logic              ctl_ready,
  output logic              ctl_kind,
  output logic [DEST_W-1:0] ctl_dest,
  input  logic              resp_valid,
  input  logic              resp_grant,
  output logic              xfer_go,
  output logic [DEST_W-1:0] xfer_dest,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done
);

  localparam int ENTRY_W = DEST_W + LEN_W;
  localparam int BO_W    = $clog2(BO_MAX) + 1;

  logic               is_long;
  logic               q_push, q_pop, q_full, q_empty;
  logic [ENTRY_W-1:0] q_head;
  logic               bo_fail, bo_success, bo_run, bo_expire;
  logic [BO_W-1:0]    bo_delay;

  assign is_long   = (req_len > cfg_threshold);
  assign pkt_valid = req_valid && !is_long;
  assign pkt_dest  = req_dest;
  assign pkt_len   = req_len;
  assign q_push    = req_valid && is_long && !q_full;
  assign req_ready = is_long ? !q_full : pkt_ready;

  hnet_setup_fifo #(
    .W     (ENTRY_W),
    .DEPTH (QDEPTH)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data ({req_dest, req_len}),
    .pop       (q_pop),
    .head      (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  hnet_backoff #(
    .INIT (BO_INIT),
    .MAX  (BO_MAX),
    .W    (BO_W)
  ) u_backoff (
    .clk     (clk),
    .rst_n   (rst_n),
    .fail    (bo_fail),
    .success (bo_success),
    .run     (bo_run),
    .expire  (bo_expire),
    .delay   (bo_delay)
  );

  hnet_circuit_fsm #(
    .DEST_W (DEST_W),
    .LEN_W  (LEN_W),
    .TO_W   (TO_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_empty     (q_empty),
    .head_dest   (q_head[ENTRY_W-1:LEN_W]),
    .head_len    (q_head[LEN_W-1:0]),
    .cfg_timeout (cfg_timeout),
    .ctl_valid   (ctl_valid),
    .ctl_ready   (ctl_ready),
    .ctl_kind    (ctl_kind),
    .ctl_dest    (ctl_dest),
    .resp_valid  (resp_valid),
    .resp_grant  (resp_grant),
    .xfer_go     (xfer_go),
    .xfer_dest   (xfer_dest),
    .xfer_len    (xfer_len),
    .xfer_done   (xfer_done),
    .q_pop       (q_pop),
    .bo_fail     (bo_fail),
    .bo_success  (bo_success),
    .bo_run      (bo_run),
    .bo_expire   (bo_expire)
  );

  AST_BACKOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bo_run |-> (!ctl_valid && !xfer_go)); // R6

  AST_SHORT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !q_push); // R2

  logic unused_delay;
  assign unused_delay = ^bo_delay;

endmodule

// File: tb/hnet_inject_ctrl_tb.sv
module hnet_inject_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int DW = 6;
  localparam int LW = 12;
  localparam int TW = 16;
  localparam int TMO = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [LW-1:0] cfg_threshold;
  logic [TW-1:0] cfg_timeout;
  logic          req_valid, req_ready;
  logic [DW-1:0] req_dest;
  logic [LW-1:0] req_len;
  logic          pkt_valid, pkt_ready;
  logic [DW-1:0] pkt_dest;
  logic [LW-1:0] pkt_len;
  logic          ctl_valid, ctl_ready, ctl_kind;
  logic [DW-1:0] ctl_dest;
  logic          resp_valid, resp_grant;
  logic          xfer_go;
  logic [DW-1:0] xfer_dest;
  logic [LW-1:0] xfer_len;
  logic          xfer_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  hnet_inject_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold), .cfg_timeout(cfg_timeout),
    .req_valid(req_valid), .req_ready(req_ready), .req_dest(req_dest), .req_len(req_len),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_dest(pkt_dest), .pkt_len(pkt_len),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_kind(ctl_kind), .ctl_dest(ctl_dest),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .xfer_go(xfer_go),
    .xfer_dest(xfer_dest), .xfer_len(xfer_len), .xfer_done(xfer_done)
  );

  function automatic bit exp_long(int len, int thr);
    return len > thr;
  endfunction

  function automatic int exp_delay(int fails_before);
    int d = 4;
    for (int i = 0; i < fails_before; i++) d = (d * 2 > 256) ? 256 : d * 2;
    return d;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_req(int dest, int len);
    @(negedge clk);
    req_valid = 1'b1; req_dest = DW'(dest); req_len = LW'(len);
    #1;
    chk(req_ready == 1'b1, "R3 long request accepted with room", int'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_ctl();
    int n = 0;
    while (!ctl_valid && n < 100) begin
      @(posedge clk); #1; n++;
    end
    chk(ctl_valid == 1'b1, "R4 control message offered", int'(ctl_valid), 1);
  endtask

  task automatic accept_ctl();
    @(negedge clk); ctl_ready = 1'b1;
    @(posedge clk); #1; ctl_ready = 1'b0;
  endtask

  task automatic respond(bit g);
    @(negedge clk); resp_valid = 1'b1; resp_grant = g;
    @(posedge clk); #1; resp_valid = 1'b0;
  endtask

  task automatic count_to_ctl(output int n);
    n = 0;
    while (!ctl_valid && n < 2000) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic finish_xfer(int dest, int len);
    chk(xfer_go == 1'b1, "R5 xfer_go after grant", int'(xfer_go), 1);
    chk(int'(xfer_dest) == dest, "R5 xfer_dest", int'(xfer_dest), dest);
    chk(int'(xfer_len) == len, "R5 xfer_len", int'(xfer_len), len);
    repeat (3) begin
      @(posedge clk); #1;
      chk(ctl_valid == 1'b0, "R9 no control message during transfer", int'(ctl_valid), 0);
    end
    @(negedge clk); xfer_done = 1'b1;
    @(posedge clk); #1; xfer_done = 1'b0;
    chk(ctl_valid && ctl_kind == 1'b1, "R9 teardown after final beat", int'(ctl_kind), 1);
    chk(int'(ctl_dest) == dest, "R9 teardown destination", int'(ctl_dest), dest);
    chk(xfer_go == 1'b0, "R9 transfer ends", int'(xfer_go), 0);
    accept_ctl();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_threshold = LW'(64); cfg_timeout = TW'(TMO);
    req_valid = 1'b0; req_dest = '0; req_len = '0; pkt_ready = 1'b0;
    ctl_ready = 1'b0; resp_valid = 1'b0; resp_grant = 1'b0; xfer_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_valid == 1'b0, "R10 ctl_valid after reset", int'(ctl_valid), 0);
    chk(xfer_go == 1'b0, "R10 xfer_go after reset", int'(xfer_go), 0);
    chk(pkt_valid == 1'b0, "R10 pkt_valid after reset", int'(pkt_valid), 0);

    // R1 R2: random steering, plus the lengths either side of the threshold
    for (int i = 0; i < 48; i++) begin
      int thr, len, dst;
      bit pr, lng;
      @(negedge clk);
      thr = $urandom_range(1, 200);
      if (i == 0) len = thr;
      else if (i == 1) len = thr + 1;
      else len = $urandom_range(0, 300);
      dst = $urandom_range(0, 63);
      pr  = 1'($urandom_range(0, 1));
      cfg_threshold = LW'(thr); req_len = LW'(len); req_dest = DW'(dst);
      pkt_ready = pr; req_valid = 1'b1;
      #1;
      lng = exp_long(len, thr);
      chk(pkt_valid == !lng, "R1 R2 steering by length", int'(pkt_valid), int'(!lng));
      if (!lng) begin
        chk(int'(pkt_dest) == dst && int'(pkt_len) == len, "R1 packet fields",
            int'(pkt_dest), dst);
        chk(req_ready == pr, "R1 ready follows packet network", int'(req_ready), int'(pr));
      end else begin
        chk(req_ready == 1'b1, "R2 long request ready with queue empty", int'(req_ready), 1);
      end
      req_valid = 1'b0;
    end
    cfg_threshold = LW'(64); pkt_ready = 1'b0;
    @(posedge clk); #1;
    chk(ctl_valid == 1'b0, "R2 nothing queued by unclocked trials", int'(ctl_valid), 0);

    // R4 R6: eight consecutive failures walk the delay up to the cap
    push_req(5, 100);
    wait_ctl();
    chk(ctl_kind == 1'b0 && int'(ctl_dest) == 5, "R4 setup fields", int'(ctl_dest), 5);
    repeat (2) @(posedge clk); #1;
    chk(ctl_valid && ctl_kind == 1'b0, "R4 setup held without ready", int'(ctl_valid), 1);
    accept_ctl();
    for (int k = 0; k < 8; k++) begin
      respond(1'b0);
      count_to_ctl(n);
      chk(n == exp_delay(k), "R6 backoff length", n, exp_delay(k));
      chk(ctl_kind == 1'b0 && int'(ctl_dest) == 5, "R6 setup resent", int'(ctl_kind), 0);
      accept_ctl();
    end
    respond(1'b1);
    finish_xfer(5, 100);

    // R7 R8: delay restarts after grant; timeout sends teardown and doubles
    push_req(9, 80);
    wait_ctl();
    accept_ctl();
    respond(1'b0);
    count_to_ctl(n);
    chk(n == exp_delay(0), "R7 delay restarted after grant", n, exp_delay(0));
    accept_ctl();
    count_to_ctl(n);
    chk(n == TMO, "R8 timeout length", n, TMO);
    chk(ctl_kind == 1'b1 && int'(ctl_dest) == 9, "R8 teardown on timeout", int'(ctl_kind), 1);
    accept_ctl();
    count_to_ctl(n);
    chk(n == exp_delay(1), "R8 timeout counted as failure", n, exp_delay(1));
    accept_ctl();
    respond(1'b1);
    finish_xfer(9, 80);

    // R3 R9: fill the queue, stall, then drain in order
    for (int i = 0; i < 8; i++) push_req(10 + i, 70 + i);
    @(negedge clk);
    req_valid = 1'b1; req_dest = DW'(40); req_len = LW'(90);
    #1;
    chk(req_ready == 1'b0, "R3 ninth long request stalled", int'(req_ready), 0);
    req_len = LW'(10); pkt_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1 && pkt_valid == 1'b1, "R3 short request passes when full",
        int'(req_ready), 1);
    req_valid = 1'b0; pkt_ready = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wait_ctl();
      chk(int'(ctl_dest) == 10 + i, "R9 arrival order", int'(ctl_dest), 10 + i);
      accept_ctl();
      respond(1'b1);
      finish_xfer(10 + i, 70 + i);
    end
    repeat (4) @(posedge clk); #1;
    chk(ctl_valid == 1'b0, "R9 idle once queue drained", int'(ctl_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule